// File: doc/BRIEF.md
# Selector Channel Block Transfer Engine

This block is a single-channel DMA engine with a byte-wide programmed-I/O register port. Software loads a start and an end address by writing bytes one at a time into a shift chain, then writes a command byte to arm the channel. It polls a status byte while the channel runs. Once the channel is armed, an attached device asks for a transfer of some number of bytes. The engine drives a memory port one byte per cycle, steps the current address upward, and tells the device how many bytes it moved. When the last byte at the end address has been moved, the channel raises its interrupt and disarms itself.

Two address modes exist. The mode is selected by `ext_mode_i`. In 16-bit mode, up to four address bytes are accepted, and a two-bit bank in the command byte supplies address bits 17:16. In extended mode, up to six bytes give full 20-bit start and end addresses. Software can read the current start address back, one byte at a time, from the most significant byte down.

Top module: `selch_dma`

## Requirements
- R1: After reset the start and end addresses, the command state, the write counter and the interrupt are all zero, and the read pointer is 1. A data read therefore returns 0x00, and a status read returns the device status with bit 3 cleared.
- R2: PIO op encoding is 0 = data read, 1 = data write, 2 = status, 3 = command. In 16-bit mode each data write moves end[15:8] into the low byte of the 16-bit start and appends the new byte to the 16-bit end. Any write after the fourth is ignored.
- R3: In extended mode up to six writes are taken. Writes one to five shift end[15:8] into the 20-bit start and set the end to {end[7:0], byte}. The sixth write shifts only the 20-bit end. A seventh or later write is ignored.
- R4: A data read returns start-address byte number p, where p is the read pointer. After the read, p decrements. When p is 0 it reloads instead, to 2 if extended mode and readback (command bit 6) are both active, and to 1 otherwise.
- R5: A command with bit 3 (stop) set keeps only bits 6 and 2 and clears GO and read. It also clears the interrupt, zeroes the write counter and reloads the read pointer using the new bit 6.
- R6: A command with bit 4 (GO) set and bit 3 clear latches bits 6, 5, 4 and 2. If four or fewer address bytes were written, both addresses are cut to 16 bits and bits 1:0 are placed at bit 16 (16-bit mode only). In 16-bit mode, bits 6 and 2 of every command are forced to zero.
- R7: On GO the start address is made even. If the end is then not above the start, the end is ORed with 0xFFFF in 16-bit mode or 0xFFFFF in extended mode.
- R8: A status read returns 0x08 while GO is set. With GO clear, it returns 0x00 if channel status (bit 2) is latched, and otherwise the device status with bit 3 cleared.
- R9: A transfer moves min(count, end - start + 1) bytes at consecutive addresses starting at the start address. When the byte at the end address is moved, the interrupt is set, GO and read are cleared, and the start register holds the end address.
- R10: A transfer request while GO is clear moves no byte and completes with a moved count of zero.
- R11: With command bit 5 (read) latched, the memory port reads (`mem_we_o` low). Otherwise it writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | 1 = extended 20-bit address mode |
| pio_sel_i | input | 1 | PIO access strobe, one cycle per access |
| pio_op_i | input | 2 | PIO operation (see R2) |
| pio_wdata_i | input | 8 | PIO write byte (address byte or command) |
| pio_rdata_o | output | 8 | PIO read byte, valid in the strobe cycle |
| dev_status_i | input | 8 | Attached device status byte |
| xfer_req_i | input | 1 | Transfer request pulse from the device |
| xfer_cnt_i | input | 8 | Requested byte count |
| xfer_done_o | output | 1 | One-cycle pulse when a request completes |
| xfer_moved_o | output | 8 | Bytes moved by the last request |
| mem_valid_o | output | 1 | Memory byte access valid |
| mem_ready_i | input | 1 | Memory accepts the byte access |
| mem_addr_o | output | 20 | Memory byte address |
| mem_we_o | output | 1 | 1 = memory write, 0 = memory read |
| mem_wdata_o | output | 8 | Byte written to memory |
| mem_rdata_i | input | 8 | Byte read from memory |
| dev_wdata_i | input | 8 | Device byte bound for memory |
| dev_rdata_o | output | 8 | Memory byte bound for the device |
| byte_ack_o | output | 1 | A byte moved this cycle |
| irq_o | output | 1 | Channel interrupt |

## Verification
A wrong write counter or a wrong shift path does not stay hidden. The next data read returns the wrong start byte, and the next GO builds the wrong transfer window. A bad read pointer shows up in the very next readback byte, as a repeated or skipped byte at the wrap. Faults in GO normalisation, the wrap mask or the end comparison show up at the end of a transfer. The moved count, the last address on the memory port and the cycle in which the interrupt rises all shift, so transfers are run right up to the 16-bit and 20-bit tops of memory.

// File: rtl/selch_pkg.sv
package selch_pkg;
  typedef enum logic [1:0] {
    PIO_RDATA = 2'd0,
    PIO_WDATA = 2'd1,
    PIO_STAT  = 2'd2,
    PIO_CMD   = 2'd3
  } pio_op_e;

  localparam int CMD_XRB  = 6;  // start-address readback in extended mode
  localparam int CMD_RD   = 5;  // memory read direction
  localparam int CMD_GO   = 4;
  localparam int CMD_STOP = 3;
  localparam int CMD_CST  = 2;  // report channel status instead of device

  localparam logic [7:0] CMD_EXT_ONLY = 8'((1 << CMD_XRB) | (1 << CMD_CST));
  localparam logic [7:0] STAT_BUSY    = 8'h08;
endpackage

// File: rtl/selch_regs.sv
module selch_regs
  import selch_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int BASE_W     = 16,
  parameter int BANK_W     = 2,
  parameter int BASE_BYTES = 4,
  parameter int EXT_BYTES  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_i,
  input  logic              pio_sel_i,
  input  pio_op_e           pio_op_i,
  input  logic [7:0]        pio_wdata_i,
  input  logic              step_i,
  output logic [7:0]        rdata_o,
  output logic [ADDR_W-1:0] sa_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic              go_o,
  output logic              rd_o,
  output logic              cst_o,
  output logic              irq_o
);
  localparam int WC_W = $clog2(EXT_BYTES + 1);
  localparam logic [ADDR_W-1:0] BASE_MASK = {{(ADDR_W-BASE_W){1'b0}}, {BASE_W{1'b1}}};
  localparam logic [ADDR_W-1:0] FULL_MASK = '1;
  localparam logic [1:0] RP_BASE = 2'(BASE_W / 8 - 1);
  localparam logic [1:0] RP_EXT  = 2'((ADDR_W + 7) / 8 - 1);

  logic [ADDR_W-1:0] sa_q, ea_q;
  logic [WC_W-1:0]   wc_q;
  logic [1:0]        rp_q;
  logic              xrb_q, rd_q, go_q, cst_q, irq_q;

  logic [7:0]        cmd_c;
  logic [BANK_W-1:0] bank;
  logic [ADDR_W-1:0] bank_addr, sa_g, ea_g, sa_go, ea_go;
  logic [ADDR_W-1:0] sh_sa_base, sh_ea_base, sh_sa_ext, sh_ea_mid, sh_ea_last;
  logic              wr_ok, is_cmd, is_wr;
  logic [31:0]       sa_w;

  assign cmd_c     = ext_i ? pio_wdata_i : (pio_wdata_i & ~CMD_EXT_ONLY);
  assign bank      = ext_i ? '0 : cmd_c[BANK_W-1:0];
  assign bank_addr = ADDR_W'(bank) << BASE_W;

  always_comb begin
    sa_g  = (wc_q <= WC_W'(BASE_BYTES)) ? ((sa_q & BASE_MASK) | bank_addr) : sa_q;
    ea_g  = (wc_q <= WC_W'(BASE_BYTES)) ? ((ea_q & BASE_MASK) | bank_addr) : ea_q;
    sa_go = sa_g & ~ADDR_W'(1);
    ea_go = (ea_g <= sa_go) ? (ea_g | (ext_i ? FULL_MASK : BASE_MASK)) : ea_g;
  end

  assign sh_sa_base = ((sa_q << 8) | (ea_q >> 8)) & BASE_MASK;
  assign sh_ea_base = ((ea_q << 8) | ADDR_W'(pio_wdata_i)) & BASE_MASK;
  assign sh_sa_ext  = (sa_q << 8) | ADDR_W'(ea_q[BASE_W-1 -: 8]);
  assign sh_ea_mid  = ADDR_W'({ea_q[7:0], pio_wdata_i});
  assign sh_ea_last = (ea_q << 8) | ADDR_W'(pio_wdata_i);
  assign wr_ok      = ext_i ? (wc_q < WC_W'(EXT_BYTES)) : (wc_q < WC_W'(BASE_BYTES));

  assign sa_w    = 32'(sa_q);
  assign rdata_o = sa_w[{rp_q, 3'b000} +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sa_q  <= '0;
      ea_q  <= '0;
      wc_q  <= '0;
      rp_q  <= 2'd1;
      xrb_q <= 1'b0;
      rd_q  <= 1'b0;
      go_q  <= 1'b0;
      cst_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (step_i) begin
        if (sa_q == ea_q) begin
          irq_q <= 1'b1;
          go_q  <= 1'b0;
          rd_q  <= 1'b0;
        end else begin
          sa_q <= sa_q + ADDR_W'(1);
        end
      end
      if (pio_sel_i) begin
        unique case (pio_op_i)
          PIO_RDATA: begin
            if (rp_q == 2'd0) rp_q <= (xrb_q && ext_i) ? RP_EXT : RP_BASE;
            else              rp_q <= rp_q - 2'd1;
          end
          PIO_WDATA: begin
            if (wr_ok) begin
              if (!ext_i) begin
                sa_q <= sh_sa_base;
                ea_q <= sh_ea_base;
              end else if (wc_q != WC_W'(EXT_BYTES - 1)) begin
                sa_q <= sh_sa_ext;
                ea_q <= sh_ea_mid;
              end else begin
                ea_q <= sh_ea_last;
              end
              wc_q <= wc_q + WC_W'(1);
            end
          end
          PIO_CMD: begin
            if (cmd_c[CMD_STOP]) begin
              xrb_q <= cmd_c[CMD_XRB];
              cst_q <= cmd_c[CMD_CST];
              go_q  <= 1'b0;
              rd_q  <= 1'b0;
              irq_q <= 1'b0;
              wc_q  <= '0;
              rp_q  <= (cmd_c[CMD_XRB] && ext_i) ? RP_EXT : RP_BASE;
            end else if (cmd_c[CMD_GO]) begin
              xrb_q <= cmd_c[CMD_XRB];
              cst_q <= cmd_c[CMD_CST];
              rd_q  <= cmd_c[CMD_RD];
              go_q  <= 1'b1;
              sa_q  <= sa_go;
              ea_q  <= ea_go;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sa_o  = sa_q;
  assign ea_o  = ea_q;
  assign go_o  = go_q;
  assign rd_o  = rd_q;
  assign cst_o = cst_q;
  assign irq_o = irq_q;

  assign is_cmd = pio_sel_i && (pio_op_i == PIO_CMD);
  assign is_wr  = pio_sel_i && (pio_op_i == PIO_WDATA);

  assert_stop_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && pio_wdata_i[CMD_STOP]) |=> (wc_q == '0 && !irq_q && !go_q));

  assert_go_even_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && !pio_wdata_i[CMD_STOP] && pio_wdata_i[CMD_GO]) |=> (!sa_q[0] && ea_q > sa_q && go_q));

  assert_full_chain_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && !step_i && wc_q >= WC_W'(BASE_BYTES) && !ext_i) |=> ($stable(sa_q) && $stable(ea_q)));

  assert_full_chain_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && !step_i && wc_q >= WC_W'(EXT_BYTES)) |=> ($stable(sa_q) && $stable(ea_q)));

  assert_end_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> (!go_q && !rd_q));
endmodule

// File: rtl/selch_xfer.sv
module selch_xfer #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] sa_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic              req_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              mem_ready_i,
  output logic              mem_valid_o,
  output logic              step_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  moved_o
);
  localparam int DW = ADDR_W + 1;

  logic             run_q, done_q;
  logic [CNT_W-1:0] left_q, moved_q, req_q, take;
  logic [DW-1:0]    remain;

  assign remain = {1'b0, ea_i} - {1'b0, sa_i} + DW'(1);
  assign take   = (DW'(cnt_i) < remain) ? cnt_i : remain[CNT_W-1:0];

  assign mem_valid_o = run_q && go_i;
  assign step_o      = mem_valid_o && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      left_q  <= '0;
      moved_q <= '0;
      req_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (req_i) begin
          req_q   <= cnt_i;
          moved_q <= '0;
          if (go_i && take != '0) begin
            run_q  <= 1'b1;
            left_q <= take;
          end else begin
            done_q <= 1'b1;
          end
        end
      end else if (!go_i) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end else if (mem_ready_i) begin
        moved_q <= moved_q + CNT_W'(1);
        left_q  <= left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o  = done_q;
  assign moved_o = moved_q;

  assert_end_is_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && sa_i == ea_i) |-> (left_q == CNT_W'(1)));

  assert_moved_le_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (moved_o <= req_q));

  assert_stop_ends_run_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !go_i) |=> (!run_q && done_o));

  assert_idle_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !run_q && !go_i) |=> (done_o && moved_o == '0));
endmodule

// File: rtl/selch_dma.sv
module selch_dma
  import selch_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int BASE_W     = 16,
  parameter int BANK_W     = 2,
  parameter int BASE_BYTES = 4,
  parameter int EXT_BYTES  = 6,
  parameter int CNT_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_mode_i,
  input  logic              pio_sel_i,
  input  logic [1:0]        pio_op_i,
  input  logic [7:0]        pio_wdata_i,
  output logic [7:0]        pio_rdata_o,
  input  logic [7:0]        dev_status_i,
  input  logic              xfer_req_i,
  input  logic [CNT_W-1:0]  xfer_cnt_i,
  output logic              xfer_done_o,
  output logic [CNT_W-1:0]  xfer_moved_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic [7:0]        dev_wdata_i,
  output logic [7:0]        dev_rdata_o,
  output logic              byte_ack_o,
  output logic              irq_o
);
  pio_op_e           op;
  logic [7:0]        rdata, status;
  logic [ADDR_W-1:0] sa, ea;
  logic              go, rd, cst, step;

  assign op = pio_op_e'(pio_op_i);

  selch_regs #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .BANK_W(BANK_W),
    .BASE_BYTES(BASE_BYTES), .EXT_BYTES(EXT_BYTES)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_i(ext_mode_i),
    .pio_sel_i(pio_sel_i), .pio_op_i(op), .pio_wdata_i(pio_wdata_i),
    .step_i(step), .rdata_o(rdata), .sa_o(sa), .ea_o(ea),
    .go_o(go), .rd_o(rd), .cst_o(cst), .irq_o(irq_o)
  );

  selch_xfer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_xfer (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .sa_i(sa), .ea_i(ea),
    .req_i(xfer_req_i), .cnt_i(xfer_cnt_i), .mem_ready_i(mem_ready_i),
    .mem_valid_o(mem_valid_o), .step_o(step),
    .done_o(xfer_done_o), .moved_o(xfer_moved_o)
  );

  always_comb begin
    if (go)       status = STAT_BUSY;
    else if (cst) status = 8'h00;
    else          status = dev_status_i & ~STAT_BUSY;
  end

  always_comb begin
    unique case (op)
      PIO_RDATA: pio_rdata_o = rdata;
      PIO_STAT:  pio_rdata_o = status;
      default:   pio_rdata_o = 8'h00;
    endcase
  end

  assign mem_addr_o  = sa;
  assign mem_we_o    = !rd;
  assign mem_wdata_o = dev_wdata_i;
  assign dev_rdata_o = mem_rdata_i;
  assign byte_ack_o  = step;

  assert_busy_status_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pio_sel_i && op == PIO_STAT && mem_valid_o) |-> (pio_rdata_o == STAT_BUSY));
endmodule

// File: tb/selch_dma_test.sv
`timescale 1ns/1ps
module selch_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext = 1'b0;
  logic        pio_sel = 1'b0;
  logic [1:0]  pio_op = 2'd0;
  logic [7:0]  pio_wdata = 8'h00;
  logic [7:0]  pio_rdata;
  logic [7:0]  dev_status = 8'hAF;
  logic        xreq = 1'b0;
  logic [7:0]  xcnt = 8'h00;
  logic        xdone;
  logic [7:0]  xmoved;
  logic        mvalid;
  logic        mready = 1'b1;
  logic [19:0] maddr;
  logic        mwe;
  logic [7:0]  mwdata, drdata;
  logic        back;
  logic        irq;

  int checks = 0;
  int errors = 0;

  int          mon_n = 0;
  logic [19:0] mon_first = '0, mon_last = '0;
  logic        mon_we = 1'b0;

  always #4 clk = ~clk;

  selch_dma uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_mode_i(ext),
    .pio_sel_i(pio_sel), .pio_op_i(pio_op), .pio_wdata_i(pio_wdata), .pio_rdata_o(pio_rdata),
    .dev_status_i(dev_status), .xfer_req_i(xreq), .xfer_cnt_i(xcnt),
    .xfer_done_o(xdone), .xfer_moved_o(xmoved),
    .mem_valid_o(mvalid), .mem_ready_i(mready), .mem_addr_o(maddr), .mem_we_o(mwe),
    .mem_wdata_o(mwdata), .mem_rdata_i(8'h5A), .dev_wdata_i(8'hC3), .dev_rdata_o(drdata),
    .byte_ack_o(back), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (mvalid && mready) begin
      if (mon_n == 0) mon_first = maddr;
      mon_last = maddr;
      mon_we   = mwe;
      mon_n++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic pio(input logic [1:0] op, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    pio_sel = 1'b1; pio_op = op; pio_wdata = d;
    #1 r = pio_rdata;
    @(negedge clk);
    pio_sel = 1'b0;
  endtask

  task automatic pw(input logic [1:0] op, input logic [7:0] d);
    logic [7:0] r;
    pio(op, d, r);
  endtask

  task automatic xfer(input logic [7:0] cnt, output logic [7:0] moved);
    mon_n = 0;
    @(negedge clk);
    xreq = 1'b1; xcnt = cnt;
    moved = 8'hEE;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      xreq = 1'b0;
      if (xdone) begin
        moved = xmoved;
        break;
      end
    end
  endtask

  // {ext, op, data, check, req, expected}
  localparam int NV = 34;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 2'd3, 8'h08, 1'b0, 4'd5,  8'h00},
    {1'b0, 2'd1, 8'h12, 1'b0, 4'd2,  8'h00},  // R2 chain load
    {1'b0, 2'd1, 8'h34, 1'b0, 4'd2,  8'h00},
    {1'b0, 2'd1, 8'h56, 1'b0, 4'd2,  8'h00},
    {1'b0, 2'd1, 8'h79, 1'b0, 4'd2,  8'h00},
    {1'b0, 2'd1, 8'h9A, 1'b0, 4'd2,  8'h00},  // fifth write ignored
    {1'b0, 2'd0, 8'h00, 1'b1, 4'd2,  8'h12},  // R2 / R4
    {1'b0, 2'd0, 8'h00, 1'b1, 4'd4,  8'h34},
    {1'b0, 2'd0, 8'h00, 1'b1, 4'd4,  8'h12},  // R4 wrap to 1
    {1'b0, 2'd2, 8'h00, 1'b1, 4'd8,  8'hA7},  // R8 device status
    {1'b0, 2'd3, 8'h11, 1'b0, 4'd6,  8'h00},  // GO bank 1
    {1'b0, 2'd2, 8'h00, 1'b1, 4'd8,  8'h08},  // R8 busy
    {1'b0, 2'd3, 8'h4C, 1'b0, 4'd6,  8'h00},  // R6 ext-only bits dropped
    {1'b0, 2'd2, 8'h00, 1'b1, 4'd6,  8'hA7},
    {1'b0, 2'd0, 8'h00, 1'b1, 4'd6,  8'h12},
    {1'b0, 2'd0, 8'h00, 1'b1, 4'd6,  8'h34},
    {1'b1, 2'd3, 8'h48, 1'b0, 4'd5,  8'h00},
    {1'b1, 2'd1, 8'h01, 1'b0, 4'd3,  8'h00},  // R3 chain load
    {1'b1, 2'd1, 8'h23, 1'b0, 4'd3,  8'h00},
    {1'b1, 2'd1, 8'h45, 1'b0, 4'd3,  8'h00},
    {1'b1, 2'd1, 8'h67, 1'b0, 4'd3,  8'h00},
    {1'b1, 2'd1, 8'h89, 1'b0, 4'd3,  8'h00},
    {1'b1, 2'd1, 8'hAB, 1'b0, 4'd3,  8'h00},
    {1'b1, 2'd1, 8'hCD, 1'b0, 4'd3,  8'h00},  // seventh ignored
    {1'b1, 2'd0, 8'h00, 1'b1, 4'd3,  8'h01},
    {1'b1, 2'd0, 8'h00, 1'b1, 4'd3,  8'h23},
    {1'b1, 2'd0, 8'h00, 1'b1, 4'd3,  8'h45},
    {1'b1, 2'd0, 8'h00, 1'b1, 4'd4,  8'h01},  // R4 wrap to 2
    {1'b1, 2'd3, 8'h14, 1'b0, 4'd6,  8'h00},
    {1'b1, 2'd2, 8'h00, 1'b1, 4'd8,  8'h08},
    {1'b1, 2'd3, 8'h0C, 1'b0, 4'd5,  8'h00},
    {1'b1, 2'd2, 8'h00, 1'b1, 4'd8,  8'h00},  // R8 channel status
    {1'b1, 2'd0, 8'h00, 1'b1, 4'd5,  8'h23},  // R5 pointer reloads to 1
    {1'b1, 2'd0, 8'h00, 1'b1, 4'd7,  8'h44}   // R7 start forced even
  };

  task automatic load(input logic [7:0] b [6], input int n);
    for (int i = 0; i < n; i++) pw(2'd1, b[i]);
  endtask

  initial begin
    logic [7:0] r, mv;
    logic [7:0] bytes [6];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 mem_valid", 32'(mvalid), 32'h0);
    chk("R1 done", 32'(xdone), 32'h0);
    pio(2'd0, 8'h00, r); chk("R1 readback", 32'(r), 32'h00);
    pio(2'd2, 8'h00, r); chk("R1 status", 32'(r), 32'hA7);

    // R10 request while idle
    xfer(8'd5, mv);
    chk("R10 moved", 32'(mv), 32'h0);
    chk("R10 bytes", 32'(mon_n), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      ext = v[23];
      pio(v[22:21], v[20:13], r);
      if (v[12]) begin
        checks++;
        if (r !== v[7:0]) begin
          errors++;
          $display("FAIL table vec %0d R%0d act=%h exp=%h", i, v[11:8], r, v[7:0]);
        end
      end
    end

    // R9 / R11: read-direction transfer hitting end
    ext = 1'b0;
    pw(2'd3, 8'h08);
    bytes = '{8'h00, 8'h10, 8'h00, 8'h13, 8'h00, 8'h00};
    load(bytes, 4);
    pw(2'd3, 8'h30);
    pio(2'd2, 8'h00, r); chk("R8 busy during GO", 32'(r), 32'h08);
    xfer(8'd10, mv);
    chk("R9 moved min", 32'(mv), 32'd4);
    chk("R9 bytes", 32'(mon_n), 32'd4);
    chk("R9 first addr", 32'(mon_first), 32'h10);
    chk("R9 last addr", 32'(mon_last), 32'h13);
    chk("R11 read dir", 32'(mon_we), 32'h0);
    chk("R9 irq", 32'(irq), 32'h1);
    pio(2'd2, 8'h00, r); chk("R9 GO cleared", 32'(r), 32'hA7);
    pio(2'd0, 8'h00, r); chk("R9 sa hi", 32'(r), 32'h00);
    pio(2'd0, 8'h00, r); chk("R9 sa at end", 32'(r), 32'h13);
    xfer(8'd3, mv);
    chk("R10 after end", 32'(mv), 32'h0);
    pw(2'd3, 8'h08);
    chk("R5 irq cleared", 32'(irq), 32'h0);

    // R9 / R11 partial write-direction transfers
    bytes = '{8'h00, 8'h21, 8'h00, 8'h40, 8'h00, 8'h00};
    load(bytes, 4);
    pw(2'd3, 8'h10);
    xfer(8'd3, mv);
    chk("R9 partial moved", 32'(mv), 32'd3);
    chk("R7 even first", 32'(mon_first), 32'h20);
    chk("R9 partial last", 32'(mon_last), 32'h22);
    chk("R11 write dir", 32'(mon_we), 32'h1);
    chk("R9 no irq", 32'(irq), 32'h0);
    xfer(8'd2, mv);
    chk("R9 resume first", 32'(mon_first), 32'h23);
    chk("R9 resume last", 32'(mon_last), 32'h24);
    pw(2'd3, 8'h08);

    // R6 bank bits in 16-bit mode
    bytes = '{8'h01, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00};
    load(bytes, 4);
    pw(2'd3, 8'h13);
    xfer(8'd9, mv);
    chk("R6 bank moved", 32'(mv), 32'd2);
    chk("R6 bank first", 32'(mon_first), 32'h30100);
    chk("R6 bank last", 32'(mon_last), 32'h30101);
    pw(2'd3, 8'h08);

    // R7 16-bit end wrap
    bytes = '{8'hFF, 8'hF0, 8'h00, 8'h05, 8'h00, 8'h00};
    load(bytes, 4);
    pw(2'd3, 8'h10);
    xfer(8'd100, mv);
    chk("R7 wrap16 moved", 32'(mv), 32'd16);
    chk("R7 wrap16 last", 32'(mon_last), 32'hFFFF);
    chk("R7 wrap16 irq", 32'(irq), 32'h1);
    pw(2'd3, 8'h08);

    // R7 / R3 extended end wrap
    ext = 1'b1;
    pw(2'd3, 8'h08);
    bytes = '{8'h0F, 8'hFF, 8'hF0, 8'h00, 8'h00, 8'h10};
    load(bytes, 6);
    pw(2'd3, 8'h10);
    xfer(8'd100, mv);
    chk("R7 wrap20 moved", 32'(mv), 32'd16);
    chk("R3 wrap20 first", 32'(mon_first), 32'hFFFF0);
    chk("R7 wrap20 last", 32'(mon_last), 32'hFFFFF);
    pw(2'd3, 8'h08);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule